// File: doc/BRIEF.md
# Windowed Watchdog Timer with Two-Write Refresh Key

This block is a watchdog timer on a small register bus. A down-counter is started, and later restarted, by a two-write key sent to a refresh register: a write of 00h, then a write of FFh as the very next write to that register. Software picks the timeout length, a prescaler ratio, and a refresh window. The window is bounded by an upper count limit (the open position) and a lower count limit (the close position). A key that completes while the count is outside the window is refused and reported as a refresh error.

The counter advances only in cycles where `cnt_en` is high, so the surrounding logic can supply a slow tick. When the count runs out, the underflow flag is set. A status register holds both flags. While either flag is set, one of two outputs is held high: the interrupt line or the reset-request line, chosen by an action register. The control register and the action register each take a single write, and only before the first refresh. This keeps a runaway program from turning the watchdog off.

Top module: `wwdt_top`

## Requirements
- R1: The registers sit at even byte addresses: refresh key at 0, control at 2, status at 4, action at 6. After reset the control, status and action registers read 0, the refresh register always reads 00FFh, an odd address reads 0, and both outputs are low.
- R2: A refresh takes place only when the low byte 00h is written to address 0 and the next write to address 0 carries FFh. A write of any other value in that position cancels the key, so a following FFh does nothing.
- R3: The first refresh loads the counter with period−1 and starts it. With `cnt_en` held high and prescaler ratio D, status bit 0 (underflow) sets exactly P·D cycles after the refresh edge. The counter then reloads and runs on, so a second underflow follows P·D cycles later.
- R4: Control bits [1:0] set the period P: 00 gives 1024, 01 gives 4096, 10 gives 8192, 11 gives 16384 counter steps.
- R5: Control bits [7:4] set the prescaler ratio D: 0000 gives 1, 0001 gives 4, 0010 gives 16, 0011 gives 32, 0100 gives 64, 0101 gives 256. Every other code gives 1.
- R6: In a cycle with `cnt_en` low, neither the prescaler nor the counter moves.
- R7: Let Q = P/4. Control bits [13:12] (codes 00, 01, 10, 11) set the open limit to Q·(code+1)−1. Control bits [9:8] (codes 00, 01, 10, 11) set the close limit to Q·(3−code). Once the counter is running, a key is accepted only when close limit ≤ count ≤ open limit. Open code 11 with close code 11 accepts every count. A close limit above the open limit accepts no count.
- R8: An accepted key reloads the counter. A refused key leaves the count alone and sets status bit 1 (refresh error).
- R9: The control register and the action register each accept only their first write, and only before the first refresh. Every later write to them is ignored.
- R10: A write to address 4 clears each status flag whose written bit is 0 and leaves each flag whose written bit is 1. Writing 0 therefore clears both flags.
- R11: While either status flag is set, `irq_o` is high if action bit 7 is 0, and `sys_rst_o` is high if action bit 7 is 1. The two outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for the current bus cycle |
| bus_addr | input | 3 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| cnt_en | input | 1 | Counter clock enable |
| irq_o | output | 1 | Interrupt request, level |
| sys_rst_o | output | 1 | System reset request, level |

## Verification
The window rule is tried by sending a second key after a chosen number of cycles under several control settings. The settings cover a full window, a mid-range window, and two windows that cannot be met. The chosen delays put the count one step inside and one step outside each limit, so an off-by-one error at either bound gives a different error flag. The timeout is measured at exactly P·D−1 and P·D cycles for several period and prescaler codes, so a wrong decode or a counter that misses one step shows up as a flag that sets too early or too late. Further patterns check the following: a cancelled key, a key sent after a long pause in `cnt_en`, accepted and refused refreshes (the latter separated by whether the original underflow time still holds), partial status clears, and the action select.

// File: rtl/wwdt_pkg.sv
// Package: shared register selectors, control layout and decode helpers
// for the windowed watchdog. Assumes the control word layout below.
package wwdt_pkg;

    // Widest prescaler shift that div_shift can return
    localparam int DIV_LOG2_MAX = 8;

    typedef enum logic [1:0] {
        SEL_KEY  = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_STAT = 2'd2,
        SEL_ACT  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [1:0] rsv_hi;
        logic [1:0] win_open;
        logic [1:0] rsv_mid;
        logic [1:0] win_close;
        logic [3:0] div_sel;
        logic [1:0] rsv_lo;
        logic [1:0] len_sel;
    } ctrl_t;

    // Period code to left shift of the base period
    function automatic logic [2:0] len_shift(input logic [1:0] code);
        case (code)
            2'b00:   return 3'd0;
            2'b01:   return 3'd2;
            2'b10:   return 3'd3;
            default: return 3'd4;
        endcase
    endfunction

    // Prescaler code to log2 of the division ratio
    function automatic logic [3:0] div_shift(input logic [3:0] code);
        case (code)
            4'd1:    return 4'd2;
            4'd2:    return 4'd4;
            4'd3:    return 4'd5;
            4'd4:    return 4'd6;
            4'd5:    return 4'd8;
            default: return 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/wwdt_prescale.sv
// Module: prescaler for the watchdog counter. A free-running count is
// masked to the selected ratio and gives a one-cycle tick each time the
// masked bits are all ones. Assumes DIV_W >= the widest shift in the package.
module wwdt_prescale
    import wwdt_pkg::*;
#(
    parameter int DIV_W = DIV_LOG2_MAX
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       en,
    input  logic       clr,
    input  logic [3:0] div_sel,
    output logic       tick
);

    logic [DIV_W-1:0] pre_q;
    logic [DIV_W:0]   span;
    logic [DIV_W-1:0] mask;

    // Mask of the low bits that make up one prescaled step
    always_comb begin
        span = (DIV_W+1)'(1) << div_shift(div_sel);
        mask = DIV_W'(span - 1'b1);
        tick = run && en && ((pre_q & mask) == mask);
    end

    // Prescale counter: cleared on a reload, advances on enabled cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clr) begin
            pre_q <= '0;
        end else if (run && en) begin
            pre_q <= pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/wwdt_timer.sv
// Module: down-counter, window compare and refresh decision. Works out
// the period and the window limits from the control fields, loads on an
// accepted key, and reports underflow and refused keys as one-cycle
// events. Assumes the control fields are static while running.
module wwdt_timer
    import wwdt_pkg::*;
#(
    parameter int BASE_LOG2 = 10,
    parameter int DIV_W     = DIV_LOG2_MAX,
    parameter int CNT_W     = BASE_LOG2 + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             key_done,
    input  logic [1:0]       len_sel,
    input  logic [1:0]       win_open,
    input  logic [1:0]       win_close,
    input  logic [3:0]       div_sel,
    output logic             running,
    output logic             reload,
    output logic             in_win,
    output logic             uf_evt,
    output logic             err_evt,
    output logic [CNT_W-1:0] cnt_q
);

    localparam int WIDE_W = CNT_W + 2;

    logic [WIDE_W-1:0] period;
    logic [WIDE_W-1:0] quarter;
    logic [WIDE_W-1:0] open_lim;
    logic [WIDE_W-1:0] close_lim;
    logic [CNT_W-1:0]  load_val;
    logic              run_q;
    logic              tick;

    // Period, load value and window limits from the control fields
    always_comb begin
        period    = (WIDE_W'(1) << BASE_LOG2) << len_shift(len_sel);
        quarter   = period >> 2;
        open_lim  = quarter * (WIDE_W'(win_open) + WIDE_W'(1)) - WIDE_W'(1);
        close_lim = quarter * WIDE_W'(2'd3 - win_close);
        load_val  = CNT_W'(period - WIDE_W'(1));
    end

    // Refresh decision and event generation
    always_comb begin
        in_win  = (WIDE_W'(cnt_q) <= open_lim) && (WIDE_W'(cnt_q) >= close_lim);
        reload  = key_done && (!run_q || in_win);
        err_evt = key_done && run_q && !in_win;
        uf_evt  = tick && (cnt_q == '0) && !reload;
        running = run_q;
    end

    wwdt_prescale #(
        .DIV_W (DIV_W)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_q),
        .en      (cnt_en),
        .clr     (reload),
        .div_sel (div_sel),
        .tick    (tick)
    );

    // Counter and run state: a reload wins over a step, underflow wraps to the top
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (reload) begin
            cnt_q <= load_val;
            run_q <= 1'b1;
        end else if (tick) begin
            cnt_q <= (cnt_q == '0) ? load_val : cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/wwdt_regs.sv
// Module: register file for the watchdog. Decodes the bus, tracks the
// two-write refresh key, keeps the write-once control and action
// registers, and holds the sticky status flags. Assumes one bus access
// per cycle and a combinational read.
module wwdt_regs
    import wwdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [2:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    input  logic        running,
    input  logic        uf_evt,
    input  logic        err_evt,
    output logic [15:0] bus_rdata,
    output logic [15:0] ctrl_q,
    output logic [7:0]  act_q,
    output logic        act_done,
    output logic        uf_flag,
    output logic        err_flag,
    output logic        key_done
);

    reg_sel_e sel;
    logic     hit;
    logic     wr_key;
    logic     wr_ctrl;
    logic     wr_stat;
    logic     wr_act;
    logic     armed_q;
    logic     ctrl_done;

    // Address decode and write strobes
    always_comb begin
        hit      = (bus_addr[0] == 1'b0);
        sel      = reg_sel_e'(bus_addr[2:1]);
        wr_key   = bus_we && hit && (sel == SEL_KEY);
        wr_ctrl  = bus_we && hit && (sel == SEL_CTRL);
        wr_stat  = bus_we && hit && (sel == SEL_STAT);
        wr_act   = bus_we && hit && (sel == SEL_ACT);
        key_done = wr_key && armed_q && (bus_wdata[7:0] == 8'hFF);
    end

    // Key tracker: 00h arms, and the next key write either completes or cancels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (wr_key) begin
            armed_q <= !armed_q && (bus_wdata[7:0] == 8'h00);
        end
    end

    // Write-once control and action registers, closed once running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            ctrl_done <= 1'b0;
            act_q     <= '0;
            act_done  <= 1'b0;
        end else begin
            if (wr_ctrl && !ctrl_done && !running) begin
                ctrl_q    <= bus_wdata;
                ctrl_done <= 1'b1;
            end
            if (wr_act && !act_done && !running) begin
                act_q    <= bus_wdata[7:0];
                act_done <= 1'b1;
            end
        end
    end

    // Sticky status flags: a new event wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uf_flag  <= 1'b0;
            err_flag <= 1'b0;
        end else begin
            uf_flag  <= (wr_stat ? (uf_flag  && bus_wdata[0]) : uf_flag)  || uf_evt;
            err_flag <= (wr_stat ? (err_flag && bus_wdata[1]) : err_flag) || err_evt;
        end
    end

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            case (sel)
                SEL_KEY:  bus_rdata = 16'h00FF;
                SEL_CTRL: bus_rdata = ctrl_q;
                SEL_STAT: bus_rdata = {14'b0, err_flag, uf_flag};
                default:  bus_rdata = {8'b0, act_q};
            endcase
        end
    end

endmodule

// File: rtl/wwdt_top.sv
// Module: windowed watchdog top. Joins the register file and the timer
// and turns the status flags into the selected output line.
// Assumes cnt_en is synchronous to clk.
module wwdt_top
    import wwdt_pkg::*;
#(
    parameter int BASE_LOG2 = 10,
    parameter int DIV_W     = DIV_LOG2_MAX
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [2:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        cnt_en,
    output logic        irq_o,
    output logic        sys_rst_o
);

    localparam int CNT_W = BASE_LOG2 + 4;

    logic [15:0]      ctrl_q;
    ctrl_t            ctrl_f;
    logic [7:0]       act_q;
    logic             act_done;
    logic             uf_flag;
    logic             err_flag;
    logic             key_done;
    logic             running;
    logic             reload;
    logic             in_win;
    logic             uf_evt;
    logic             err_evt;
    logic [CNT_W-1:0] cnt_q;

    assign ctrl_f = ctrl_t'(ctrl_q);

    wwdt_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .running   (running),
        .uf_evt    (uf_evt),
        .err_evt   (err_evt),
        .bus_rdata (bus_rdata),
        .ctrl_q    (ctrl_q),
        .act_q     (act_q),
        .act_done  (act_done),
        .uf_flag   (uf_flag),
        .err_flag  (err_flag),
        .key_done  (key_done)
    );

    wwdt_timer #(
        .BASE_LOG2 (BASE_LOG2),
        .DIV_W     (DIV_W),
        .CNT_W     (CNT_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_en    (cnt_en),
        .key_done  (key_done),
        .len_sel   (ctrl_f.len_sel),
        .win_open  (ctrl_f.win_open),
        .win_close (ctrl_f.win_close),
        .div_sel   (ctrl_f.div_sel),
        .running   (running),
        .reload    (reload),
        .in_win    (in_win),
        .uf_evt    (uf_evt),
        .err_evt   (err_evt),
        .cnt_q     (cnt_q)
    );

    // Output select: a pending flag drives the line chosen by action bit 7
    always_comb begin
        irq_o     = (uf_flag || err_flag) && !act_q[7];
        sys_rst_o = (uf_flag || err_flag) &&  act_q[7];
    end

endmodule

// File: rtl/wwdt_chk.sv
// Module: assertion checker for the windowed watchdog, bound to wwdt_top.
// Assumes the internal signals keep the names used in the bind below.
module wwdt_chk #(
    parameter int CNT_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic             irq_o,
    input logic             sys_rst_o,
    input logic             running,
    input logic             key_done,
    input logic             uf_evt,
    input logic             err_evt,
    input logic             uf_flag,
    input logic             err_flag,
    input logic             act_done,
    input logic [15:0]      ctrl_q,
    input logic [7:0]       act_q,
    input logic [CNT_W-1:0] cnt_q
);

    AST_OUT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_o && sys_rst_o)); // R11

    AST_FIRST_KEY_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (key_done && !running) |=> running); // R3

    AST_UF_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        uf_evt |=> uf_flag); // R3

    AST_CNT_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !cnt_en && !key_done) |=> $stable(cnt_q)); // R6

    AST_REFUSED_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (err_evt && cnt_q != '0) |=> (cnt_q <= $past(cnt_q))); // R8

    AST_REFUSED_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |=> err_flag); // R8

    AST_CTRL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> $stable(ctrl_q)); // R9

    AST_ACT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        act_done |=> $stable(act_q)); // R9

endmodule

bind wwdt_top wwdt_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .irq_o     (irq_o),
    .sys_rst_o (sys_rst_o),
    .running   (running),
    .key_done  (key_done),
    .uf_evt    (uf_evt),
    .err_evt   (err_evt),
    .uf_flag   (uf_flag),
    .err_flag  (err_flag),
    .act_done  (act_done),
    .ctrl_q    (ctrl_q),
    .act_q     (act_q),
    .cnt_q     (cnt_q)
);

// File: tb/wwdt_top_bench.sv
module wwdt_top_bench;

    localparam int WATCHDOG = 190000;

    // {control word, wait cycles before second key, expected refresh error}
    localparam logic [32:0] VEC [0:11] = '{
        {16'h3300, 16'd0,    1'b0},
        {16'h2200, 16'd0,    1'b1},
        {16'h2200, 16'd300,  1'b0},
        {16'h2200, 16'd800,  1'b1},
        {16'h0000, 16'd500,  1'b1},
        {16'h1100, 16'd511,  1'b1},
        {16'h1200, 16'd511,  1'b0},
        {16'h1200, 16'd510,  1'b1},
        {16'h2200, 16'd766,  1'b0},
        {16'h2200, 16'd767,  1'b1},
        {16'h2210, 16'd1023, 1'b0},
        {16'h2210, 16'd1022, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        cnt_en = 1'b1;
    logic        irq_o;
    logic        sys_rst_o;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;
    logic [15:0] d;

    always #10 clk = ~clk;

    wwdt_top u_wwdt_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_en    (cnt_en),
        .irq_o     (irq_o),
        .sys_rst_o (sys_rst_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n  = 1'b0;
        bus_we = 1'b0;
        cnt_en = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] v);
        bus_addr  = a;
        bus_wdata = v;
        bus_we    = 1'b1;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        bus_addr = a;
        bus_we   = 1'b0;
        #1 v = bus_rdata;
    endtask

    task automatic key();
        wr(3'd0, 16'h0000);
        wr(3'd0, 16'h00FF);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // Reset state and register map (R1)
        do_reset();
        rd(3'd0, d); check("R1", "key reg read",  d, 16'h00FF);
        rd(3'd2, d); check("R1", "ctrl reset",    d, 16'h0000);
        rd(3'd4, d); check("R1", "status reset",  d, 16'h0000);
        rd(3'd6, d); check("R1", "action reset",  d, 16'h0000);
        rd(3'd3, d); check("R1", "odd address",   d, 16'h0000);
        check("R1", "irq after reset", irq_o, 1'b0);
        check("R1", "rst after reset", sys_rst_o, 1'b0);

        // Window vectors (R7, R8, R11)
        for (int i = 0; i < 12; i++) begin
            do_reset();
            wr(3'd2, VEC[i][32:17]);
            key();
            wait_cyc(int'(VEC[i][16:1]));
            key();
            rd(3'd4, d);
            check("R7", $sformatf("vector %0d refresh error", i), d[1], VEC[i][0]);
            check("R11", $sformatf("vector %0d irq", i), irq_o, VEC[i][0]);
        end

        // Write-once registers before start (R9)
        do_reset();
        wr(3'd2, 16'h3300);
        wr(3'd2, 16'h0001);
        rd(3'd2, d); check("R9", "ctrl second write", d, 16'h3300);
        wr(3'd6, 16'h0080);
        wr(3'd6, 16'h0000);
        rd(3'd6, d); check("R9", "action second write", d, 16'h0080);

        // Cancelled key does not start (R2), then timeout and reload (R3, R4)
        do_reset();
        wr(3'd0, 16'h0000);
        wr(3'd0, 16'h005A);
        wr(3'd0, 16'h00FF);
        wr(3'd2, 16'h3300);
        rd(3'd2, d); check("R2", "ctrl still open after cancelled key", d, 16'h3300);
        key();
        wait_cyc(1023);
        rd(3'd4, d); check("R3", "no underflow at P-1", d[0], 1'b0);
        wait_cyc(1);
        rd(3'd4, d); check("R4", "underflow at P=1024", d[0], 1'b1);
        check("R11", "irq on underflow", irq_o, 1'b1);
        check("R11", "no reset line", sys_rst_o, 1'b0);
        wr(3'd6, 16'h0080);
        rd(3'd6, d); check("R9", "action write after start", d, 16'h0000);
        wr(3'd4, 16'h0000);
        rd(3'd4, d); check("R10", "status cleared", d, 16'h0000);
        check("R10", "irq dropped after clear", irq_o, 1'b0);
        wait_cyc(1021);
        rd(3'd4, d); check("R3", "no second underflow early", d[0], 1'b0);
        wait_cyc(1);
        rd(3'd4, d); check("R3", "second underflow after wrap", d[0], 1'b1);
        wr(3'd4, 16'h0001);
        rd(3'd4, d); check("R10", "bit written 1 keeps flag", d[0], 1'b1);
        wr(3'd4, 16'h0000);
        rd(3'd4, d); check("R10", "bit written 0 clears flag", d[0], 1'b0);

        // Longest period (R4)
        do_reset();
        wr(3'd2, 16'h3303);
        key();
        wait_cyc(16383);
        rd(3'd4, d); check("R4", "no underflow at 16383", d[0], 1'b0);
        wait_cyc(1);
        rd(3'd4, d); check("R4", "underflow at 16384", d[0], 1'b1);

        // Prescaler divide by 4 (R5)
        do_reset();
        wr(3'd2, 16'h3310);
        key();
        wait_cyc(4095);
        rd(3'd4, d); check("R5", "div4 no underflow at 4095", d[0], 1'b0);
        wait_cyc(1);
        rd(3'd4, d); check("R5", "div4 underflow at 4096", d[0], 1'b1);

        // Prescaler divide by 256 reaching the window open limit (R5)
        do_reset();
        wr(3'd2, 16'h2250);
        key();
        wait_cyc(65535);
        key();
        rd(3'd4, d); check("R5", "div256 count 767 accepted", d, 16'h0000);

        // Enable gating (R6)
        do_reset();
        wr(3'd2, 16'h3300);
        key();
        cnt_en = 1'b0;
        wait_cyc(2000);
        rd(3'd4, d); check("R6", "no underflow while disabled", d[0], 1'b0);
        cnt_en = 1'b1;
        wait_cyc(1023);
        rd(3'd4, d); check("R6", "no underflow at P-1 enabled", d[0], 1'b0);
        wait_cyc(1);
        rd(3'd4, d); check("R6", "underflow after P enabled", d[0], 1'b1);

        // Accepted key reloads (R8)
        do_reset();
        wr(3'd2, 16'h3300);
        key();
        wait_cyc(500);
        key();
        wait_cyc(1023);
        rd(3'd4, d); check("R8", "reload postponed underflow", d, 16'h0000);
        wait_cyc(1);
        rd(3'd4, d); check("R8", "underflow P after reload", d[0], 1'b1);

        // Refused key keeps the count (R8)
        do_reset();
        wr(3'd2, 16'h2200);
        key();
        key();
        rd(3'd4, d); check("R8", "refused key flags", d, 16'h0002);
        check("R11", "irq on refresh error", irq_o, 1'b1);
        wait_cyc(1021);
        rd(3'd4, d); check("R8", "no underflow before original time", d[0], 1'b0);
        wait_cyc(1);
        rd(3'd4, d); check("R8", "underflow at original time", d[0], 1'b1);

        // Reset action select (R11)
        do_reset();
        wr(3'd2, 16'h3300);
        wr(3'd6, 16'h0080);
        key();
        wait_cyc(1023);
        check("R11", "reset line low before underflow", sys_rst_o, 1'b0);
        wait_cyc(1);
        check("R11", "reset line on underflow", sys_rst_o, 1'b1);
        check("R11", "irq low in reset mode", irq_o, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule